// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small byte-wide serial EEPROM. The SCL and SDA lines are brought into the system clock domain through a short synchronizer chain. The synchronized lines are then watched for START, STOP and clock edges. After a START, the block collects a device address byte. That byte carries a fixed device-type code, the strap bits and a direction flag. If the address matches, the block acknowledges it and then carries out a write, a current-address read or a random read on its internal array.

The block only ever pulls SDA low, through an open-drain drive enable. The number of strap pins that take part in address matching is set by a parameter (`PIN_CMP`, from 3 down to 0). Device-address bits that are not compared become the upper memory address bits. Each of these bits selects one 256-byte block. A write-protect input turns the whole array read-only. After a stored write, a busy timer makes the block ignore its address for a fixed number of clock cycles. This models the internal program time.

Top module: `eeprom_i2c_target`

## Requirements
- R1: Out of reset, the SDA drive enable is low. Bus bits clocked without a preceding START (SDA falling while SCL is high) are never acknowledged.
- R2: A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle. Bits that follow without a new START are ignored. A repeated START restarts device address reception.
- R3: The device address byte is acknowledged only when its bits 7:4 equal 4'b1010.
- R4: Bits 3:1 of the device address byte correspond to strap pins A2, A1, A0. Only the upper `PIN_CMP` of them are compared with `dev_pins_i`. Each remaining bit selects a 256-byte block: it becomes memory address bit 8 and up, with A0 as the lowest block bit.
- R5: On an address match, SDA is held low through the ninth SCL clock and released after its falling edge.
- R6: A write is device byte with bit 0 = 0, then word address, then data. Each byte is acknowledged. The data byte is stored at {block, word address}, and the address pointer then advances by one.
- R7: While `wp_i` is high, data bytes are still acknowledged, but the array is left unchanged.
- R8: A read (device byte bit 0 = 1) shifts out the byte at the address pointer, MSB first. The pointer advances after each byte and wraps at the top of the array.
- R9: A random read is a write carrying only a word address, then a repeated START and a read. It returns the byte at that address.
- R10: A master ACK after a read byte makes the block send the next byte. A master NACK ends the read with SDA released.
- R11: A STOP that follows at least one stored data byte starts a busy window of `BUSY_CYCLES` clocks. During this window, device addresses are not acknowledged. A write in which nothing was stored starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired result) |
| dev_pins_i | input | 3 | Strap pins {A2, A1, A0} for address matching |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| sda_oe_o | output | 1 | Open-drain enable: high pulls SDA low |

## Verification
Two events can coincide at the end of a write. The STOP that commits a write arms the busy timer. The address comparison of the next transaction then lands inside that window. The bench provokes this by issuing a START and a device address directly after the STOP of a stored write. It expects a NACK, then an ACK once the window has elapsed, and it reads back the stored byte. The same edge that writes a data byte also advances the pointer. A later sequential read across several addresses, including the wrap from the top block to address zero, shows that the store and the advance did not disturb each other.

// File: rtl/eei_pkg.sv
package eei_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } eei_state_e;
endpackage

// File: rtl/eei_line_cond.sv
module eei_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
          sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eei_busy_timer.sv
module eei_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic busy
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (arm) cnt_n = CW'(BUSY_CYCLES);
    else if (cnt != '0) cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else cnt <= cnt_n;
  end

  assign busy = (cnt != '0);

  // R11: arming the timer opens the busy window on the next cycle
  p_arm_opens_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> busy);
endmodule

// File: rtl/eei_mem.sv
module eei_mem #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eei_ctrl.sv
module eei_ctrl
  import eei_pkg::*;
#(
  parameter int unsigned PIN_CMP = 3,
  parameter int unsigned AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        dev_pins,
  input  logic              wp,
  input  logic              busy,
  output logic              busy_arm,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [AW-1:0]     mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sda_oe
);
  localparam int unsigned BLK_BITS = 3 - PIN_CMP;
  localparam logic [2:0]  PIN_MASK = 3'(3'b111 << BLK_BITS);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  eei_state_e state, state_n, ret, ret_n;
  logic [3:0]        bcnt, bcnt_n;
  logic [BYTE_W-1:0] sr, sr_n;
  logic [AW-1:0]     ptr, ptr_n;
  logic [2:0]        blk, blk_n;
  logic              mack, mack_n;
  logic              oe, oe_n;
  logic              pend, pend_n;
  logic              dev_hit;
  logic              upd;

  assign dev_hit = (sr[7:4] == TYPE_CODE) &&
                   (((sr[3:1] ^ dev_pins) & PIN_MASK) == 3'b000) && !busy;
  assign upd = scl_rise | scl_fall | start_evt | stop_evt;

  always_comb begin
    state_n  = state;
    ret_n    = ret;
    bcnt_n   = bcnt;
    sr_n     = sr;
    ptr_n    = ptr;
    blk_n    = blk;
    mack_n   = mack;
    oe_n     = oe;
    pend_n   = pend;
    mem_we   = 1'b0;
    busy_arm = 1'b0;
    if (stop_evt) begin
      state_n  = ST_IDLE;
      oe_n     = 1'b0;
      busy_arm = pend;
      pend_n   = 1'b0;
    end else if (start_evt) begin
      state_n = ST_DEV;
      bcnt_n  = 4'd0;
      oe_n    = 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bcnt < 4'd8) begin
            sr_n   = {sr[6:0], sda_s};
            bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            if (state == ST_DEV) begin
              if (dev_hit) begin
                oe_n    = 1'b1;
                state_n = ST_ACK;
                ret_n   = sr[0] ? ST_RDATA : ST_WADDR;
                blk_n   = sr[3:1];
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              oe_n    = 1'b1;
              state_n = ST_ACK;
              ret_n   = ST_WDATA;
              ptr_n   = AW'({blk, sr});
            end else begin
              oe_n    = 1'b1;
              state_n = ST_ACK;
              ret_n   = ST_WDATA;
              ptr_n   = ptr + PTR_ONE;
              if (!wp) begin
                mem_we = 1'b1;
                pend_n = 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bcnt_n  = 4'd0;
            state_n = ret;
            if (ret == ST_RDATA) begin
              sr_n = mem_rdata;
              oe_n = ~mem_rdata[7];
            end else begin
              oe_n = 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              oe_n    = 1'b0;
              state_n = ST_RACK;
              ptr_n   = ptr + PTR_ONE;
            end else begin
              sr_n   = {sr[6:0], 1'b0};
              oe_n   = ~sr[6];
              bcnt_n = bcnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state_n = ST_RDATA;
              bcnt_n  = 4'd0;
              sr_n    = mem_rdata;
              oe_n    = ~mem_rdata[7];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ret   <= ST_IDLE;
      bcnt  <= 4'd0;
      sr    <= '0;
      ptr   <= '0;
      blk   <= 3'b000;
      mack  <= 1'b0;
      oe    <= 1'b0;
      pend  <= 1'b0;
    end else if (upd) begin
      state <= state_n;
      ret   <= ret_n;
      bcnt  <= bcnt_n;
      sr    <= sr_n;
      ptr   <= ptr_n;
      blk   <= blk_n;
      mack  <= mack_n;
      oe    <= oe_n;
      pend  <= pend_n;
    end
  end

  assign mem_waddr = ptr;
  assign mem_wdata = sr;
  assign mem_raddr = ptr;
  assign sda_oe    = oe;

  // R1: nothing is driven on the bus while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !oe);

  // R2: a STOP releases the line and returns to idle
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!oe && state == ST_IDLE));

  // R3: a wrong type code is never acknowledged
  p_type_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && scl_fall && bcnt == 4'd8 && sr[7:4] != TYPE_CODE) |=> !oe);

  // R5: the acknowledge slot always pulls the line low
  p_ack_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK) |-> oe);

  // R11: an address arriving during the busy window is dropped
  p_busy_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == ST_DEV && scl_fall && bcnt == 4'd8) |=> (!oe && state == ST_IDLE));
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eei_pkg::*;
#(
  parameter int unsigned PIN_CMP     = 3,
  parameter int unsigned BUSY_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int unsigned BLK_BITS = 3 - PIN_CMP;
  localparam int unsigned AW       = BYTE_W + BLK_BITS;

  logic [1:0] rst_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, busy_arm, mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  eei_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eei_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n_s), .arm(busy_arm), .busy(busy)
  );

  eei_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  eei_ctrl #(.PIN_CMP(PIN_CMP), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_pins(dev_pins_i), .wp(wp_i), .busy(busy), .busy_arm(busy_arm),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .sda_oe(sda_oe_o)
  );

  // R7: the array write strobe never fires while write protect is high
  p_wp_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_we |-> !wp_i);
endmodule

// File: tb/tb_eeprom_i2c_target.sv
`timescale 1ns/1ps
module tb_eeprom_i2c_target;
  localparam int unsigned BUSY = 2000;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m, wp;
  logic [2:0] pins;
  logic sda_oe, sda_bus;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eeprom_i2c_target #(.PIN_CMP(2), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .dev_pins_i(pins), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  // {block bit, word address, data}
  localparam logic [16:0] VEC [7] = '{
    {1'b0, 8'h10, 8'hAA}, {1'b1, 8'h10, 8'h55}, {1'b0, 8'h00, 8'h5A},
    {1'b1, 8'hFF, 8'h3C}, {1'b0, 8'h30, 8'hA1}, {1'b0, 8'h31, 8'hB2},
    {1'b0, 8'h32, 8'hC3}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic blk, input logic rw);
    return {4'b1010, 2'b10, blk, rw};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; wt(8); scl = 1'b1; wt(16); sda_m = 1'b0; wt(16); scl = 1'b0; wt(8);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(8); scl = 1'b1; wt(16); sda_m = 1'b1; wt(16);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(8); scl = 1'b1; wt(16); scl = 1'b0; wt(8);
    end
    sda_m = 1'b1; wt(8); scl = 1'b1; wt(8); ack = ~sda_bus; wt(8); scl = 1'b0; wt(8);
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(8); scl = 1'b1; wt(8); b[i] = sda_bus; wt(8); scl = 1'b0; wt(8);
    end
    sda_m = ~mack; wt(8); scl = 1'b1; wt(16); scl = 1'b0; wt(8); sda_m = 1'b1;
  endtask

  task automatic wr(input logic blk, input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    i2c_start(); tx_byte(devb(blk, 1'b0), k0); tx_byte(a, k1); tx_byte(d, k2); i2c_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic rd_at(input logic blk, input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    i2c_start(); tx_byte(devb(blk, 1'b0), k0); tx_byte(a, k1);
    i2c_start(); tx_byte(devb(blk, 1'b1), k2); rx_byte(1'b0, d); i2c_stop();
    ok = k0 & k1 & k2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok, k, k1;
    logic [7:0] d, d2, d3;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; wp = 1'b0; pins = 3'b101;
    wt(10);
    check("R1 reset drive enable", sda_oe, 1'b0);
    rst_n = 1'b1; wt(10);

    // R1: address bits without a START are not acknowledged
    scl = 1'b0; wt(8);
    tx_byte(devb(1'b0, 1'b0), k);
    check("R1 no START no ack", k, 1'b0);
    scl = 1'b1; wt(16);

    // R6 and R4: table of writes across both blocks
    foreach (VEC[i]) begin
      wr(VEC[i][16], VEC[i][15:8], VEC[i][7:0], ok);
      check("R6 write acked", ok, 1'b1);
      if (i == 0) check("R5 line released after ack", sda_oe, 1'b0);
      wt(BUSY + 100);
    end
    // R9 and R4: random read-back of every entry
    foreach (VEC[i]) begin
      rd_at(VEC[i][16], VEC[i][15:8], d, ok);
      check("R9 random read acked", ok, 1'b1);
      check("R4 R9 random read data", d, VEC[i][7:0]);
    end

    // R3: wrong type code
    i2c_start(); tx_byte(8'b1011_1000, k); i2c_stop();
    check("R3 wrong type code", k, 1'b0);

    // R4: compared pin A1 mismatch
    i2c_start(); tx_byte(8'b1010_1100, k); i2c_stop();
    check("R4 A1 mismatch", k, 1'b0);

    // R10 and R8: sequential read with master ACK then NACK
    i2c_start(); tx_byte(devb(1'b0, 1'b0), k); tx_byte(8'h30, k);
    i2c_start(); tx_byte(devb(1'b0, 1'b1), k);
    rx_byte(1'b1, d); rx_byte(1'b0, d2); i2c_stop();
    check("R10 first byte", d, 8'hA1);
    check("R10 after master ACK", d2, 8'hB2);
    check("R2 R10 released after STOP", sda_oe, 1'b0);
    // R8: current-address read continues at 0x32
    i2c_start(); tx_byte(devb(1'b0, 1'b1), k); rx_byte(1'b0, d3); i2c_stop();
    check("R8 current address ack", k, 1'b1);
    check("R8 current address data", d3, 8'hC3);

    // R8: pointer wraps from top of block 1 to address 0 of block 0
    i2c_start(); tx_byte(devb(1'b1, 1'b0), k); tx_byte(8'hFF, k);
    i2c_start(); tx_byte(devb(1'b1, 1'b1), k);
    rx_byte(1'b1, d); rx_byte(1'b0, d2); i2c_stop();
    check("R8 top byte", d, 8'h3C);
    check("R8 wrap to zero", d2, 8'h5A);

    // R2: after STOP, bits without a new START are ignored
    scl = 1'b0; wt(8);
    tx_byte(devb(1'b0, 1'b1), k);
    check("R2 ignored after STOP", k, 1'b0);
    scl = 1'b1; wt(16);

    // R7: protected write is acked but not stored, no busy window
    wp = 1'b1;
    wr(1'b0, 8'h10, 8'hEE, ok);
    check("R7 protected write acked", ok, 1'b1);
    wp = 1'b0;
    i2c_start(); tx_byte(devb(1'b0, 1'b0), k); i2c_stop();
    check("R11 no busy after protected write", k, 1'b1);
    rd_at(1'b0, 8'h10, d, ok);
    check("R7 array unchanged", d, 8'hAA);

    // R11: address right after a stored write is refused, later accepted
    wr(1'b0, 8'h50, 8'h66, ok);
    i2c_start(); tx_byte(devb(1'b0, 1'b0), k); i2c_stop();
    check("R11 nack while busy", k, 1'b0);
    wt(BUSY + 100);
    i2c_start(); tx_byte(devb(1'b0, 1'b0), k1); i2c_stop();
    check("R11 ack after busy", k1, 1'b1);
    rd_at(1'b0, 8'h50, d, ok);
    check("R11 stored byte", d, 8'h66);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule